// File: doc/BRIEF.md
# Lockable Chip-Select Bus Controller

This block gates and times accesses to an external memory bus with four chip selects. Each chip select has a small control register. The register sets the access length in bus cycles, marks the memory as synchronous or asynchronous, records the data width, and holds a write-enable bit. A host reaches the registers through a simple register port. The control registers can only be changed after a key value has been written to a lock register, so stray writes during boot cannot change the bus setup.

On the bus side a requester offers one read or write at a time and tags it with a chip-select number. A sequencer with three states handles each request:

- IDLE accepts a request. It moves to ACCESS when the access is allowed, and to BLOCKED when the request is a write to a chip select whose write-enable bit is clear.
- ACCESS drives the chip-select strobe, and the write strobe for writes, for the programmed number of cycles. It pulses the acknowledge in the last cycle and then returns to IDLE.
- BLOCKED lasts one cycle. It acknowledges the request with no strobe, raises a sticky flag that the host can see, and returns to IDLE.

Top module: `ebus_cs_ctrl`

## Requirements
- R1: After reset the configuration is locked, every control register reads 0x00, so write enable is off for the flash chip select (1) and all others, the sticky flag is clear and the bus side is idle.
- R2: Control registers for chip selects 0, 1, 2 and 3 sit at register offsets 0x00, 0x04, 0x08 and 0x0C. Each holds 8 bits: [7:4] length code, [3] synchronous, [2] write enable, [1:0] width (00 8-bit, 01 16-bit, 10 32-bit). They read back in rdata[7:0] with upper bits 0, whether locked or not. Unmapped offsets read 0.
- R3: Writing 0xA05F to the lock register at offset 0x20 unlocks the configuration. Writes to control registers while locked leave them unchanged.
- R4: Writing any other value to offset 0x20 locks the configuration again.
- R5: Reading offset 0x20 returns bit 0 = 1 while unlocked, bit 1 = the sticky write-blocked flag, and 0 in all other bits.
- R6: An allowed access holds exactly one bit of cs_strobe, the one for the requested chip select, for L cycles. L = code+2 for length codes 0 to 13, and L = 16 for codes 14 and 15. The strobe starts in the cycle after acceptance.
- R7: ack is a one-cycle pulse in the last strobe cycle. busy is high for the whole access. A request presented while busy is ignored.
- R8: An allowed write holds wr_strobe for the same cycles as cs_strobe. A read never raises wr_strobe.
- R9: A write to a chip select whose write-enable bit is 0 raises no strobe. It is acknowledged in the cycle after acceptance and sets the sticky flag.
- R10: The sticky flag stays set until the host writes offset 0x20 with bit 8 = 1. If a block and a clear occur in the same cycle, the block wins.
- R11: During an access, acc_sync and acc_width show the captured bits of the selected chip select. Width code 11 reads back as 11 but is presented as 10 (32-bit). Both outputs are 0 when no access is in progress.
- R12: The configuration of a chip select is captured when its request is accepted. Register changes during an access do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| req_valid | input | 1 | Bus request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Chip select of the request |
| cs_strobe | output | 4 | One-hot chip-select strobe |
| wr_strobe | output | 1 | Write strobe |
| ack | output | 1 | Access complete pulse |
| busy | output | 1 | Sequencer not idle |
| acc_sync | output | 1 | Synchronous flag of the current access |
| acc_width | output | 2 | Effective width of the current access |

## Verification
The accesses cover the shortest length code, a one-step code, code 13 and both saturating codes 14 and 15. This tells a correct n+2 mapping with saturation apart from off-by-one or unsaturated decodes. Writes are aimed both at enabled and at disabled chip selects, and reads at a disabled one. This separates write gating from read handling and from the flag logic. Control-register writes are tried before unlock, after unlock and after relock, which exposes a lock that ignores the key or never closes. A block and a flag clear are placed in the same cycle to test their priority, and a write is pushed at the sequencer mid-access to test that busy requests are dropped.

// File: rtl/ebus_cs_pkg.sv
package ebus_cs_pkg;

    localparam int          WAIT_W     = 4;
    localparam int          MAX_LEN    = 16;
    localparam int          SAT_CODE   = MAX_LEN - 2;
    localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
    localparam int          CTRL_W     = 8;
    localparam int          LOCK_OFS   = 32;
    localparam int          CLR_BIT    = 8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_BLOCKED = 2'd2
    } acc_state_e;

    typedef struct packed {
        logic [WAIT_W-1:0] wait_n;
        logic              sync;
        logic              wr_en;
        logic [1:0]        width;
    } cs_ctrl_t;

    localparam cs_ctrl_t CTRL_RESET = '0;

endpackage

// File: rtl/ebus_len_decode.sv
module ebus_len_decode
    import ebus_cs_pkg::*;
(
    input  logic [WAIT_W-1:0] wait_n,
    output logic [WAIT_W-1:0] len_m1
);

    // cycles minus one: code+1, saturating at MAX_LEN-1
    assign len_m1 = (int'(wait_n) >= SAT_CODE) ? WAIT_W'(MAX_LEN - 1)
                                               : wait_n + WAIT_W'(1);

endmodule

// File: rtl/ebus_cfg_regs.sv
module ebus_cfg_regs
    import ebus_cs_pkg::*;
#(
    parameter int N_CS   = 4,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic                  blk_set,
    output logic [DATA_W-1:0]     reg_rdata,
    output cs_ctrl_t [N_CS-1:0]   ctrl_q,
    output logic                  unlocked,
    output logic                  blk_flag
);

    logic lock_hit;
    assign lock_hit = (reg_addr == ADDR_W'(LOCK_OFS));

    for (genvar i = 0; i < N_CS; i++) begin : g_ctrl
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(i * 4);
        cs_ctrl_t r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r_q <= CTRL_RESET;
            else if (reg_we && unlocked && reg_addr == OFS)
                r_q <= cs_ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
        assign ctrl_q[i] = r_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            unlocked <= 1'b0;
        else if (reg_we && lock_hit)
            unlocked <= (reg_wdata == DATA_W'(UNLOCK_KEY));
    end

    // set has priority over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            blk_flag <= 1'b0;
        else if (blk_set)
            blk_flag <= 1'b1;
        else if (reg_we && lock_hit && reg_wdata[CLR_BIT])
            blk_flag <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < N_CS; i++) begin
            if (reg_addr == ADDR_W'(i * 4))
                reg_rdata[CTRL_W-1:0] = ctrl_q[i];
        end
        if (lock_hit)
            reg_rdata[1:0] = {blk_flag, unlocked};
    end

endmodule

// File: rtl/ebus_access_fsm.sv
module ebus_access_fsm
    import ebus_cs_pkg::*;
#(
    parameter int N_CS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [$clog2(N_CS)-1:0]  req_cs,
    input  cs_ctrl_t [N_CS-1:0]      ctrl_q,
    output logic [N_CS-1:0]          cs_strobe,
    output logic                     wr_strobe,
    output logic                     ack,
    output logic                     busy,
    output logic                     acc_sync,
    output logic [1:0]               acc_width,
    output logic                     blk_set
);

    localparam int CS_W = $clog2(N_CS);

    acc_state_e        st_q, st_d;
    logic [WAIT_W-1:0] cnt_q;
    logic [CS_W-1:0]   cs_q;
    logic              wr_q;
    logic              sync_q;
    logic [1:0]        width_q;

    cs_ctrl_t          sel;
    logic [WAIT_W-1:0] len_m1;

    assign sel = ctrl_q[req_cs];

    ebus_len_decode u_len (
        .wait_n (sel.wait_n),
        .len_m1 (len_m1)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (req_valid)
                            st_d = (req_write && !sel.wr_en) ? ST_BLOCKED : ST_ACCESS;
            ST_ACCESS:  if (cnt_q == '0) st_d = ST_IDLE;
            ST_BLOCKED: st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            cs_q    <= '0;
            wr_q    <= 1'b0;
            sync_q  <= 1'b0;
            width_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && req_valid) begin
                cnt_q   <= len_m1;
                cs_q    <= req_cs;
                wr_q    <= req_write;
                sync_q  <= sel.sync;
                width_q <= sel.width;
            end else if (st_q == ST_ACCESS && cnt_q != '0) begin
                cnt_q <= cnt_q - WAIT_W'(1);
            end
        end
    end

    always_comb begin
        cs_strobe = '0;
        wr_strobe = 1'b0;
        ack       = 1'b0;
        busy      = 1'b0;
        acc_sync  = 1'b0;
        acc_width = '0;
        blk_set   = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_ACCESS: begin
                cs_strobe[cs_q] = 1'b1;
                wr_strobe       = wr_q;
                ack             = (cnt_q == '0);
                busy            = 1'b1;
                acc_sync        = sync_q;
                acc_width       = (width_q == 2'b11) ? 2'b10 : width_q;
            end
            ST_BLOCKED: begin
                ack     = 1'b1;
                busy    = 1'b1;
                blk_set = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ebus_cs_ctrl.sv
module ebus_cs_ctrl
    import ebus_cs_pkg::*;
#(
    parameter int N_CS   = 4,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [$clog2(N_CS)-1:0]  req_cs,
    output logic [N_CS-1:0]          cs_strobe,
    output logic                     wr_strobe,
    output logic                     ack,
    output logic                     busy,
    output logic                     acc_sync,
    output logic [1:0]               acc_width
);

    cs_ctrl_t [N_CS-1:0] ctrl_q;
    logic                unlocked;
    logic                blk_flag;
    logic                blk_set;

    ebus_cfg_regs #(
        .N_CS   (N_CS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .blk_set   (blk_set),
        .reg_rdata (reg_rdata),
        .ctrl_q    (ctrl_q),
        .unlocked  (unlocked),
        .blk_flag  (blk_flag)
    );

    ebus_access_fsm #(
        .N_CS (N_CS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_cs    (req_cs),
        .ctrl_q    (ctrl_q),
        .cs_strobe (cs_strobe),
        .wr_strobe (wr_strobe),
        .ack       (ack),
        .busy      (busy),
        .acc_sync  (acc_sync),
        .acc_width (acc_width),
        .blk_set   (blk_set)
    );

endmodule

// File: rtl/ebus_cs_ctrl_chk.sv
module ebus_cs_ctrl_chk #(
    parameter int N_CS   = 4,
    parameter int ADDR_W = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_we,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [N_CS-1:0]     cs_strobe,
    input logic                wr_strobe,
    input logic                ack,
    input logic                busy,
    input logic                unlocked,
    input logic                blk_flag,
    input logic [N_CS*8-1:0]   ctrl_bits
);

    // R3
    lock_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && reg_we && reg_addr < ADDR_W'(N_CS * 4)) |=> $stable(ctrl_bits));

    // R6
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_strobe));

    // R6
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_strobe != '0 && !ack) |=> ($stable(cs_strobe) && $stable(wr_strobe)));

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R7
    ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> busy);

    // R8
    wr_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> (cs_strobe != '0));

    // R9
    blocked_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && cs_strobe == '0) |=> blk_flag);

endmodule

bind ebus_cs_ctrl ebus_cs_ctrl_chk #(
    .N_CS   (N_CS),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .cs_strobe (cs_strobe),
    .wr_strobe (wr_strobe),
    .ack       (ack),
    .busy      (busy),
    .unlocked  (unlocked),
    .blk_flag  (blk_flag),
    .ctrl_bits (ctrl_q)
);

// File: tb/ebus_cs_ctrl_bench.sv
`timescale 1ns/1ps
module ebus_cs_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_cs = '0;
    logic [3:0]  cs_strobe;
    logic        wr_strobe, ack, busy, acc_sync;
    logic [1:0]  acc_width;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    ebus_cs_ctrl u_ebus_cs_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_write(req_write), .req_cs(req_cs), .cs_strobe(cs_strobe),
        .wr_strobe(wr_strobe), .ack(ack), .busy(busy), .acc_sync(acc_sync),
        .acc_width(acc_width)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ctrl[4];
    bit m_unl, m_flag, m_blk, m_wr;
    int m_left, m_cs, m_cfg;

    function automatic int len_of(int c);
        int n;
        n = (c >> 4) & 15;
        return (n >= 14) ? 16 : n + 2;
    endfunction

    function automatic logic [15:0] m_read(logic [5:0] a);
        if (a == 6'h20) return {14'b0, m_flag, m_unl};
        if (a[1:0] == 2'b00 && a < 6'h10) return 16'(m_ctrl[a >> 2]);
        return 16'h0;
    endfunction

    always @(posedge clk) begin
        bit set_flag;
        set_flag = 0;
        if (!rst_n) begin
            foreach (m_ctrl[i]) m_ctrl[i] = 0;
            m_unl = 0; m_flag = 0; m_blk = 0; m_wr = 0;
            m_left = 0; m_cs = 0; m_cfg = 0;
        end else begin
            if (m_left > 0) m_left--;
            else if (m_blk) begin m_blk = 0; set_flag = 1; end
            else if (req_valid) begin
                if (req_write && ((m_ctrl[req_cs] >> 2) & 1) == 0) m_blk = 1;
                else begin
                    m_left = len_of(m_ctrl[req_cs]);
                    m_cs = int'(req_cs); m_wr = req_write; m_cfg = m_ctrl[req_cs];
                end
            end
            if (reg_we) begin
                if (reg_addr == 6'h20) begin
                    if (reg_wdata[8]) m_flag = 0;
                    m_unl = (reg_wdata == 16'hA05F);
                end else if (m_unl && reg_addr[1:0] == 2'b00 && reg_addr < 6'h10)
                    m_ctrl[reg_addr >> 2] = int'(reg_wdata[7:0]);
            end
            if (set_flag) m_flag = 1;
        end
    end

    // per-cycle comparison, well after the negedge drive
    always @(negedge clk) begin
        #5;
        if (rst_n && !done) begin
            int w;
            w = m_cfg & 3;
            check("R6 cs_strobe", 32'(cs_strobe), (m_left > 0) ? (32'd1 << m_cs) : 32'd0);
            check("R8 wr_strobe", 32'(wr_strobe), 32'(m_left > 0 && m_wr));
            check("R7 ack", 32'(ack), 32'(m_left == 1 || m_blk));
            check("R7 busy", 32'(busy), 32'(m_left > 0 || m_blk));
            check("R11 acc_sync", 32'(acc_sync), (m_left > 0) ? 32'((m_cfg >> 3) & 1) : 32'd0);
            check("R11 acc_width", 32'(acc_width), (m_left > 0) ? 32'((w == 3) ? 2 : w) : 32'd0);
            check("R2 rdata", 32'(reg_rdata), 32'(m_read(reg_addr)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic reg_write(logic [5:0] a, logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_expect(string tag, logic [5:0] a, logic [15:0] exp);
        @(negedge clk);
        reg_addr = a;
        #5;
        check(tag, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic access(string tag, int cs, bit wr, int exp_len);
        int n, wn, guard;
        n = 0; wn = 0; guard = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_cs = 2'(cs);
        @(negedge clk);
        req_valid = 1'b0;
        #5;
        while (!ack && guard < 40) begin
            guard++;
            if (cs_strobe != '0) n++;
            if (wr_strobe) wn++;
            @(negedge clk);
            #5;
        end
        if (cs_strobe != '0) n++;
        if (wr_strobe) wn++;
        check(tag, 32'(n), 32'(exp_len));
        check({tag, " wr cycles"}, 32'(wn), wr ? 32'(exp_len) : 32'd0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_expect("R1 lock reg after reset", 6'h20, 16'h0000);
        reg_expect("R1 flash ctrl after reset", 6'h04, 16'h0000);
        check("R1 busy after reset", 32'(busy), 32'd0);

        // R3 locked writes ignored
        reg_write(6'h04, 16'h0004);
        reg_expect("R3 locked write ignored", 6'h04, 16'h0000);

        // R3/R5 unlock
        reg_write(6'h20, 16'hA05F);
        reg_expect("R5 unlocked readback", 6'h20, 16'h0001);
        reg_write(6'h00, 16'h0000);
        reg_write(6'h04, 16'h001D);
        reg_write(6'h08, 16'hFFE7);
        reg_write(6'h0C, 16'h00F2);
        reg_expect("R2 cs1 readback", 6'h04, 16'h001D);
        reg_expect("R11 reserved width stored", 6'h08, 16'h00E7);
        reg_expect("R2 cs3 readback", 6'h0C, 16'h00F2);
        reg_expect("R2 unmapped offset", 6'h10, 16'h0000);

        // R4 relock
        reg_write(6'h20, 16'h0000);
        reg_expect("R4 relocked", 6'h20, 16'h0000);
        reg_write(6'h00, 16'h00FF);
        reg_expect("R4 write after relock ignored", 6'h00, 16'h0000);

        // R6/R8 lengths
        access("R6 read cs0 code0 len", 0, 1'b0, 2);
        access("R8 write cs1 code1 len", 1, 1'b1, 3);
        access("R6 read cs2 code14 len", 2, 1'b0, 16);
        access("R6 read cs3 code15 len", 3, 1'b0, 16);

        // R9 blocked write, R10 clear
        access("R9 blocked write cs3 strobes", 3, 1'b1, 0);
        reg_expect("R9 flag raised", 6'h20, 16'h0002);
        reg_write(6'h20, 16'h0100);
        reg_expect("R10 flag cleared", 6'h20, 16'h0000);
        access("R9 blocked write cs0 strobes", 0, 1'b1, 0);
        reg_write(6'h20, 16'hA05F);
        reg_expect("R10 flag sticky over unlock", 6'h20, 16'h0003);
        reg_write(6'h20, 16'h0100);

        // R10 set wins over clear in same cycle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_cs = 2'd3;
        @(negedge clk);
        req_valid = 1'b0;
        reg_we = 1'b1; reg_addr = 6'h20; reg_wdata = 16'h0100;
        @(negedge clk);
        reg_we = 1'b0;
        reg_expect("R10 set beats clear", 6'h20, 16'h0002);
        reg_write(6'h20, 16'h0100);

        // R6 code 13
        reg_write(6'h20, 16'hA05F);
        reg_write(6'h00, 16'h00D4);
        reg_write(6'h20, 16'h0000);
        access("R6 write cs0 code13 len", 0, 1'b1, 15);

        // R7 requests ignored while busy; R12 mid-access change
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_cs = 2'd2;
        @(negedge clk);
        req_valid = 1'b0;
        reg_we = 1'b1; reg_addr = 6'h20; reg_wdata = 16'hA05F;
        @(negedge clk);
        reg_addr = 6'h08; reg_wdata = 16'h0000;
        @(negedge clk);
        reg_we = 1'b0;
        req_valid = 1'b1; req_write = 1'b1; req_cs = 2'd3;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (16) @(negedge clk);
        reg_expect("R7 busy request ignored", 6'h20, 16'h0001);
        check("R12 idle after captured length", 32'(busy), 32'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule